// File: doc/BRIEF.md
# Real-Time Clock with Alarms

This block keeps wall-clock time from a 32.768 kHz input. A prescaler turns the input into a one-second advance strobe. The strobe steps a seconds counter, which carries into minutes, then hours, then a free-running day count. Two alarm comparators watch the time. The daily comparator ignores the day. The dated comparator also needs the day to match. A countdown stopwatch loses one count per second and raises a flag when it reaches zero.

A host reaches every value through a small register port. Writes take effect on the next clock edge. Read data is registered and follows the address by one cycle. There are three sticky event flags, each with its own interrupt enable, and one interrupt output.

The timekeeping registers are deliberately left out of the system reset. A chip reset therefore loses neither the time, nor the alarm settings, nor the stopwatch. Clearing the prescaler enable makes the counters step on every input clock, which lets a test cover long spans of time quickly.

Top module: `rtc_core`

## Requirements
- R1: With the prescaler enabled, the time advances once every CLK_HZ input cycles. Counting starts afresh when the enable goes from 0 to 1. With the prescaler disabled, the time advances on every input cycle.
- R2: Each advance steps seconds 0..59, carrying into minutes 0..59, then into hours 0..23, then into the day count. The day count is DAY_W bits wide and wraps from its maximum to 0.
- R3: A write to the TIME register (address 0) loads all fields on that edge and overrides the advance due on that edge. Field positions are: seconds in [5:0], minutes in [11:6], hours in [16:12], day in [16+DAY_W:17]. A seconds or minutes field of 60 or more loads as 0, and so does an hours field of 24 or more.
- R4: `host_rdata` shows, one cycle after `host_addr`, the register at that address:
  - 0: time
  - 1: daily alarm
  - 2: dated alarm
  - 3: stopwatch, in [SW_W-1:0]
  - 4: status
  - 5: control

  Addresses 6 and 7 read as 0. Both alarm registers use the TIME field layout.
- R5: When an advance makes hours, minutes and seconds equal the daily alarm, status bit 0 is set, whatever the day.
- R6: Status bit 1 is set only when an advance makes the day, hours, minutes and seconds all equal the dated alarm.
- R7: On each advance the stopwatch decrements, and it holds at 0. Status bit 2 is set on the advance that takes it from 1 to 0. Writing 0 sets no flag. Writing a non-zero value re-arms the countdown.
- R8: A host write that makes the time equal an alarm value sets no alarm flag.
- R9: Status flags are sticky. Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and a set on the same edge wins over the clear.
- R10: Control bit 0 is the prescaler enable. Control bits [3:1] enable status bits [2:0] onto `irq`. `irq` goes high one cycle after an enabled flag is set, or one cycle after the enable is written.
- R11: `rst` sets control to 1 (prescaler on, interrupts off) and clears status, `irq` and `host_rdata`. It leaves the time, both alarms and the stopwatch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase, also the host clock |
| rst | input | 1 | Synchronous active-high reset of control and status |
| host_we | input | 1 | Write strobe for the addressed register |
| host_addr | input | 3 | Register address |
| host_wdata | input | 17+DAY_W | Write data |
| host_rdata | output | 17+DAY_W | Registered read data |
| irq | output | 1 | Registered OR of the enabled status flags |

## Verification
A wrong carry or wrap in the time cascade shows up on the TIME readback one cycle after the faulty advance. With the prescaler disabled, the bench therefore compares every cycle of long sweeps across minute, hour, midnight and day-wrap boundaries against arithmetic time.

A comparator or flag fault shows at `irq` within two cycles of the matching advance. A stopwatch fault shows on its readback on the very next cycle. Faults in the prescaler count only appear a full CLK_HZ cycles later, so one complete prescaled second is timed exactly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HR_W   = 5;
  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = SEC_LSB + SEC_W;
  localparam int HR_LSB  = MIN_LSB + MIN_W;
  localparam int DAY_LSB = HR_LSB + HR_W;
  localparam int TOD_W   = DAY_LSB;

  localparam int NUM_FLAGS  = 3;
  localparam int FLAG_DAILY = 0;
  localparam int FLAG_DATED = 1;
  localparam int FLAG_SW    = 2;

  typedef enum logic [2:0] {
    REG_TIME      = 3'd0,
    REG_ALM_DAILY = 3'd1,
    REG_ALM_DATED = 3'd2,
    REG_SW        = 3'd3,
    REG_STATUS    = 3'd4,
    REG_CTRL      = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CLK_HZ = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CNT_W = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = !en || (cnt_q == LAST);

  generate
    if (CLK_HZ > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> (!en || !tick)) else $error("prescaled ticks adjacent"); // R1
    end
  endgenerate
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper import rtc_pkg::*; #(
  parameter int DAY_W = 15,
  localparam int DATA_W = TOD_W + DAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] tod
);
  localparam logic [SEC_W-1:0] SEC_TOP = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_TOP = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_TOP  = HR_W'(23);

  logic [SEC_W-1:0] sec_q = '0;
  logic [MIN_W-1:0] min_q = '0;
  logic [HR_W-1:0]  hr_q  = '0;
  logic [DAY_W-1:0] day_q = '0;

  logic [SEC_W-1:0] sec_in, sec_ld;
  logic [MIN_W-1:0] min_in, min_ld;
  logic [HR_W-1:0]  hr_in, hr_ld;

  assign sec_in = wdata[MIN_LSB-1:SEC_LSB];
  assign min_in = wdata[HR_LSB-1:MIN_LSB];
  assign hr_in  = wdata[DAY_LSB-1:HR_LSB];
  assign sec_ld = (sec_in > SEC_TOP) ? '0 : sec_in;
  assign min_ld = (min_in > MIN_TOP) ? '0 : min_in;
  assign hr_ld  = (hr_in > HR_TOP) ? '0 : hr_in;

  always_ff @(posedge clk) begin
    if (load) begin
      sec_q <= sec_ld;
      min_q <= min_ld;
      hr_q  <= hr_ld;
      day_q <= wdata[DATA_W-1:DAY_LSB];
    end else if (tick) begin
      if (sec_q == SEC_TOP) begin
        sec_q <= '0;
        if (min_q == MIN_TOP) begin
          min_q <= '0;
          if (hr_q == HR_TOP) begin
            hr_q  <= '0;
            day_q <= day_q + 1'b1;
          end else begin
            hr_q <= hr_q + 1'b1;
          end
        end else begin
          min_q <= min_q + 1'b1;
        end
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

  assign tod = {day_q, hr_q, min_q, sec_q};

  AST_TOD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (sec_q <= SEC_TOP) && (min_q <= MIN_TOP) && (hr_q <= HR_TOP)) else $error("time field out of range"); // R2
  AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> (sec_q == (($past(sec_q) == SEC_TOP) ? '0 : $past(sec_q) + 1'b1))) else $error("seconds step wrong"); // R2
  AST_DAY_CARRY: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && sec_q == SEC_TOP && min_q == MIN_TOP && hr_q == HR_TOP)
    |=> (day_q == DAY_W'($past(day_q) + 1'b1)) && (hr_q == '0)) else $error("midnight carry wrong"); // R2
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int SW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            load,
  input  logic [SW_W-1:0] wdata,
  output logic [SW_W-1:0] count,
  output logic            expire
);
  logic [SW_W-1:0] cnt_q = '0;

  always_ff @(posedge clk) begin
    if (load)                     cnt_q <= wdata;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign count  = cnt_q;
  assign expire = tick && !load && (cnt_q == SW_W'(1));

  AST_SW_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load) |=> (cnt_q == '0)) else $error("stopwatch left zero"); // R7
  AST_SW_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("stopwatch step wrong"); // R7
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm import rtc_pkg::*; #(
  parameter int DAY_W = 15,
  parameter bit MATCH_DAY = 1'b0,
  localparam int DATA_W = TOD_W + DAY_W
) (
  input  logic              clk,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] tod,
  output logic [DATA_W-1:0] value,
  output logic              hit
);
  localparam logic [DATA_W-1:0] MASK = MATCH_DAY ? {DATA_W{1'b1}}
                                                 : {{DAY_W{1'b0}}, {TOD_W{1'b1}}};
  logic [DATA_W-1:0] alm_q = '0;

  always_ff @(posedge clk) begin
    if (load) alm_q <= wdata;
  end

  assign value = alm_q;
  assign hit   = ((tod ^ alm_q) & MASK) == '0;
endmodule

// File: rtl/rtc_core.sv
module rtc_core import rtc_pkg::*; #(
  parameter int CLK_HZ = 32768,
  parameter int DAY_W  = 15,
  parameter int SW_W   = 16,
  localparam int DATA_W = TOD_W + DAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);
  logic                 presc_en_q;
  logic [NUM_FLAGS-1:0] irq_en_q;
  logic [NUM_FLAGS-1:0] status_q;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr;
  logic                 tick, upd_q, irq_q;
  logic [DATA_W-1:0]    tod, rdata_q;
  logic [DATA_W-1:0]    alm_val [2];
  logic [1:0]           alm_hit;
  logic [SW_W-1:0]      sw_cnt;
  logic                 sw_expire;
  logic                 wr_time, wr_sw, wr_status, wr_ctrl;

  assign wr_time   = host_we && (host_addr == REG_TIME);
  assign wr_sw     = host_we && (host_addr == REG_SW);
  assign wr_status = host_we && (host_addr == REG_STATUS);
  assign wr_ctrl   = host_we && (host_addr == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_en_q <= 1'b1;
      irq_en_q   <= '0;
    end else if (wr_ctrl) begin
      presc_en_q <= host_wdata[0];
      irq_en_q   <= host_wdata[NUM_FLAGS:1];
    end
  end

  rtc_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
    .clk (clk),
    .rst (rst),
    .en  (presc_en_q),
    .tick(tick)
  );

  rtc_timekeeper #(.DAY_W(DAY_W)) u_time (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .load (wr_time),
    .wdata(host_wdata),
    .tod  (tod)
  );

  // marks a cycle whose time value came from an advance, not a host load
  always_ff @(posedge clk) begin
    if (rst) upd_q <= 1'b0;
    else     upd_q <= tick && !wr_time;
  end

  generate
    for (genvar i = 0; i < 2; i++) begin : g_alarm
      localparam logic [2:0] ALM_ADDR = (i == 0) ? REG_ALM_DAILY : REG_ALM_DATED;
      rtc_alarm #(.DAY_W(DAY_W), .MATCH_DAY(i == 1)) u_alarm (
        .clk  (clk),
        .load (host_we && (host_addr == ALM_ADDR)),
        .wdata(host_wdata),
        .tod  (tod),
        .value(alm_val[i]),
        .hit  (alm_hit[i])
      );
    end
  endgenerate

  rtc_stopwatch #(.SW_W(SW_W)) u_sw (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .load  (wr_sw),
    .wdata (host_wdata[SW_W-1:0]),
    .count (sw_cnt),
    .expire(sw_expire)
  );

  assign flag_set[FLAG_DAILY] = upd_q && alm_hit[0];
  assign flag_set[FLAG_DATED] = upd_q && alm_hit[1];
  assign flag_set[FLAG_SW]    = sw_expire;
  assign flag_clr = wr_status ? host_wdata[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~flag_clr) | flag_set;
      irq_q    <= |(status_q & irq_en_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (host_addr)
        REG_TIME:      rdata_q <= tod;
        REG_ALM_DAILY: rdata_q <= alm_val[0];
        REG_ALM_DATED: rdata_q <= alm_val[1];
        REG_SW:        rdata_q <= {{(DATA_W-SW_W){1'b0}}, sw_cnt};
        REG_STATUS:    rdata_q <= {{(DATA_W-NUM_FLAGS){1'b0}}, status_q};
        REG_CTRL:      rdata_q <= {{(DATA_W-NUM_FLAGS-1){1'b0}}, irq_en_q, presc_en_q};
        default:       rdata_q <= '0;
      endcase
    end
  end

  assign host_rdata = rdata_q;
  assign irq        = irq_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & ~flag_clr)) |=> ((status_q & $past(status_q & ~flag_clr)) == $past(status_q & ~flag_clr))) else $error("status flag lost"); // R9
  AST_SW_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (sw_cnt == '0 && $past(sw_cnt) == SW_W'(1) && !$past(wr_sw) && !$past(rst)) |-> status_q[FLAG_SW]) else $error("expiry not flagged"); // R7
endmodule

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
  localparam int CLK_HZ = 32768;
  localparam int DAY_W  = 15;
  localparam int SW_W   = 16;
  localparam logic [2:0] A_TIME = 3'd0, A_DAILY = 3'd1, A_DATED = 3'd2,
                         A_SW = 3'd3, A_STAT = 3'd4, A_CTRL = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq;
  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rtc_core #(.CLK_HZ(CLK_HZ), .DAY_W(DAY_W), .SW_W(SW_W)) u_rtc_core (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  function automatic logic [31:0] pk(input int d, input int h, input int m, input int s);
    return {d[14:0], h[4:0], m[5:0], s[5:0]};
  endfunction

  function automatic logic [31:0] adv(input logic [31:0] t, input int n);
    longint tot;
    int s, m, h, d;
    tot = ((longint'(t[31:17]) * 24 + longint'(t[16:12])) * 60 + longint'(t[11:6])) * 60
          + longint'(t[5:0]) + longint'(n);
    s = int'(tot % 60); tot = tot / 60;
    m = int'(tot % 60); tot = tot / 60;
    h = int'(tot % 24); tot = tot / 24;
    d = int'(tot % 32768);
    return pk(d, h, m, s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic sel(input logic [2:0] a);
    host_addr = a;
    @(negedge clk);
  endtask

  task automatic sweep(input logic [31:0] w, input int n, input string req);
    wr(A_TIME, w);
    host_addr = A_TIME;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check(req, host_rdata, adv(w, k - 1));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R11 rdata after reset", host_rdata, 32'h0);
    check("R11 irq after reset", {31'b0, irq}, 32'h0);
    sel(A_CTRL);  check("R11 ctrl default", host_rdata, 32'h1);
    sel(A_STAT);  check("R11 status cleared", host_rdata, 32'h0);
    sel(3'd6);    check("R4 unmapped address", host_rdata, 32'h0);

    wr(A_CTRL, 32'h0);
    sweep(pk(5, 23, 59, 50), 40, "R2 midnight carry");
    sweep(pk(32767, 23, 59, 58), 10, "R2 day wrap");
    sweep(pk(0, 0, 0, 0), 4000, "R1 R2 per-cycle advance");
    sweep(pk(17, 12, 34, 56), 3, "R3 load overrides advance");
    wr(A_TIME, pk(3, 25, 60, 61));
    sel(A_TIME); check("R3 out-of-range fields", host_rdata, pk(3, 0, 0, 0));

    wr(A_DAILY, pk(0, 10, 0, 0));
    wr(A_DATED, pk(9, 10, 0, 0));
    wr(A_CTRL, 32'he);
    wr(A_STAT, 32'h7);
    sel(A_DAILY); check("R4 daily alarm readback", host_rdata, pk(0, 10, 0, 0));
    sel(A_DATED); check("R4 dated alarm readback", host_rdata, pk(9, 10, 0, 0));
    sel(A_CTRL);  check("R4 ctrl readback", host_rdata, 32'he);
    check("R10 irq idle", {31'b0, irq}, 32'h0);

    wr(A_TIME, pk(4, 9, 59, 55));
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 6) check("R10 irq not yet", {31'b0, irq}, 32'h0);
      if (k == 7) check("R5 R10 daily irq", {31'b0, irq}, 32'h1);
    end
    sel(A_STAT); check("R5 R6 daily only, day differs", host_rdata, 32'h1);

    wr(A_STAT, 32'h1);
    wr(A_TIME, pk(9, 9, 59, 58));
    repeat (4) @(negedge clk);
    sel(A_STAT); check("R6 dated match", host_rdata, 32'h3);

    wr(A_STAT, 32'h3);
    wr(A_TIME, pk(9, 10, 0, 0));
    repeat (3) @(negedge clk);
    sel(A_STAT); check("R8 write equal to alarm", host_rdata, 32'h0);
    check("R8 irq quiet", {31'b0, irq}, 32'h0);

    wr(A_TIME, pk(9, 9, 59, 59));
    repeat (3) @(negedge clk);
    wr(A_STAT, 32'h2);
    sel(A_STAT); check("R9 partial clear", host_rdata, 32'h1);
    wr(A_STAT, 32'h1);
    sel(A_STAT); check("R9 full clear", host_rdata, 32'h0);

    wr(A_CTRL, 32'h0);
    wr(A_TIME, pk(1, 9, 59, 59));
    repeat (4) @(negedge clk);
    check("R10 disabled flag gated", {31'b0, irq}, 32'h0);
    sel(A_STAT); check("R10 flag present", host_rdata, 32'h1);
    wr(A_CTRL, 32'h2);
    check("R10 enable not yet visible", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R10 enable drives irq", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h7);

    wr(A_SW, 32'd5);
    host_addr = A_SW;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R7 countdown", host_rdata, (k <= 6) ? 32'(6 - k) : 32'h0);
    end
    sel(A_STAT); check("R7 expiry flag", host_rdata, 32'h4);
    wr(A_STAT, 32'h4);
    wr(A_SW, 32'd0);
    repeat (3) @(negedge clk);
    sel(A_STAT); check("R7 zero write no flag", host_rdata, 32'h0);
    sel(A_SW);   check("R7 holds zero", host_rdata, 32'h0);
    wr(A_SW, 32'd3);
    repeat (5) @(negedge clk);
    sel(A_STAT); check("R7 re-arm expiry", host_rdata, 32'h4);
    wr(A_SW, 32'hffff);
    host_addr = A_SW;
    @(negedge clk); check("R7 load full scale", host_rdata, 32'hffff);
    @(negedge clk); check("R7 decrement full scale", host_rdata, 32'hfffe);

    w = pk(2, 3, 4, 5);
    wr(A_TIME, w);
    wr(A_CTRL, 32'h1);
    host_addr = A_TIME;
    for (int i = 1; i <= CLK_HZ + 1; i++) begin
      @(negedge clk);
      if (i == 1)          check("R1 held after enable", host_rdata, adv(w, 1));
      if (i == CLK_HZ)     check("R1 before prescaled tick", host_rdata, adv(w, 1));
      if (i == CLK_HZ + 1) check("R1 prescaled tick", host_rdata, adv(w, 2));
    end

    wr(A_SW, 32'd100);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sel(A_TIME);  check("R11 time kept", host_rdata, adv(w, 2));
    sel(A_SW);    check("R11 stopwatch kept", host_rdata, 32'd100);
    sel(A_DATED); check("R11 alarm kept", host_rdata, pk(9, 10, 0, 0));
    sel(A_CTRL);  check("R11 ctrl reset", host_rdata, 32'h1);
    finish_run();
  end
endmodule